// File: doc/BRIEF.md
# Eight-Channel Converter Write Decoder

This block is the digital front end of an eight-channel converter. A host presents a 10-bit word, a mode qualifier and a 3-bit channel number, and pulses a write enable. With the mode qualifier low, the word is a control word. Bit 0 of a control word picks its target: the one global system register, or the control register of the addressed channel. With the mode qualifier high, the word is data for the addressed channel.

Each channel has a routing flag that sends its later data writes to one of two latches. One is a 10-bit main latch. The other is an 8-bit sub latch that holds an offset. Every channel turns both stored codes into straight-binary levels, all at once, without a clock. The main conversion follows the global coding mode, which is either twos complement or offset binary.

Top module: `dac_write_decoder`

## Requirements
- R1: After a synchronous reset, every register holds zero. So every channel routes to main, the internal bias is off, the coding is offset binary, each main level reads 0x1FF and each sub level reads 0x7F.
- R2: A write with mode low and word bit 0 clear goes to the system register, whatever the address. Word bit 5 sets the coding (1 = twos complement, 0 = offset binary), and it takes effect from the next clock edge.
- R3: A write with mode low and word bit 0 set goes to the addressed channel's control register. Word bit 7 becomes that channel's routing flag (1 = sub latch) and word bit 4 becomes its internal-bias flag.
- R4: A write with mode high to a channel whose routing flag is 0 loads the full 10-bit word into that channel's main latch and leaves its sub latch unchanged.
- R5: A write with mode high to a channel whose routing flag is 1 loads word bits 7:0 into that channel's sub latch and leaves its main latch unchanged.
- R6: In twos complement coding, main code 0x200 gives level 0 and code 0x1FF gives level 0x3FF. In general, level = (code + 512) mod 1024.
- R7: In offset binary coding, main code 0x1FF gives level 0 and code 0x200 gives level 0x3FF. In general, level = 1023 - ((code + 512) mod 1024).
- R8: The sub level is 255 - ((code + 128) mod 256), so code 0x7F gives 0 and code 0x80 gives 0xFF, in either coding mode.
- R9: While write enable is low, no register changes, whatever the mode, address and word inputs are.
- R10: A control or data write changes only the addressed channel. Every other channel keeps its latches and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable, sampled on the clock edge |
| modeSel | input | 1 | 0 = control write, 1 = data write |
| chanAddr | input | 3 | Channel number for channel control and data writes |
| wrData | input | 10 | Write word |
| mainLevel | output | 80 | Straight-binary main levels, channel n at bits 10n+9:10n |
| subLevel | output | 64 | Straight-binary sub levels, channel n at bits 8n+7:8n |
| subRoute | output | 8 | Per-channel routing flag, 1 = data goes to the sub latch |
| biasInt | output | 8 | Per-channel internal-bias select |
| codingTwos | output | 1 | 1 = twos complement coding, 0 = offset binary |

## Verification
The bench writes system words with a non-zero address. A design that decoded the address on a system write would miss those writes or send them to a channel. The bench loads the codes at the edge of each mode (0x1FF, 0x200, 0x7F, 0x80) and then flips the coding. A converter with the bit swap inverted or tied to the wrong mode would show up at once, as would a sub level that wrongly followed the coding. The bench moves a channel's routing flag back and forth between data writes. A decoder that ignored the flag, used a stale flag, or wrote both latches would corrupt the latch that should stay fixed. Idle cycles with random control inputs, and a check of every non-addressed channel after each write, catch stray write enables and wrong channel selection.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  localparam int DWD_NCH      = 8;
  localparam int DWD_ADDR_W   = $clog2(DWD_NCH);
  localparam int DWD_WORD_W   = 10;
  localparam int DWD_SUB_W    = 8;
  // control word field positions
  localparam int DWD_SEL_BIT    = 0;  // 0 = system register, 1 = channel register
  localparam int DWD_BIAS_BIT   = 4;
  localparam int DWD_CODING_BIT = 5;
  localparam int DWD_ROUTE_BIT  = 7;

  typedef struct packed {
    logic                  sysWr;
    logic                  ctlWr;
    logic                  datWr;
    logic [DWD_ADDR_W-1:0] chan;
  } dwdStrobe_t;
endpackage

// File: rtl/dwd_ctrl.sv
module dwd_ctrl
  import dwd_pkg::*;
#(
  parameter int WORD_W  = DWD_WORD_W,
  parameter int SEL_BIT = DWD_SEL_BIT
) (
  input  logic                  wrEn,
  input  logic                  modeSel,
  input  logic [DWD_ADDR_W-1:0] chanAddr,
  input  logic [WORD_W-1:0]     wrData,
  output dwdStrobe_t            strb
);
  always_comb begin
    strb      = '0;
    strb.chan = chanAddr;
    if (wrEn) begin
      if (modeSel)              strb.datWr = 1'b1;
      else if (wrData[SEL_BIT]) strb.ctlWr = 1'b1;
      else                      strb.sysWr = 1'b1;
    end
  end
endmodule

// File: rtl/dwd_level_conv.sv
module dwd_level_conv #(
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8
) (
  input  logic              twos,
  input  logic [MAIN_W-1:0] mainCode,
  input  logic [SUB_W-1:0]  subCode,
  output logic [MAIN_W-1:0] mainLvl,
  output logic [SUB_W-1:0]  subLvl
);
  localparam int MSB  = MAIN_W - 1;
  localparam int SMSB = SUB_W - 1;

  always_comb begin
    if (twos) mainLvl = {~mainCode[MSB], mainCode[MSB-1:0]};
    else      mainLvl = {mainCode[MSB], ~mainCode[MSB-1:0]};
    subLvl = {subCode[SMSB], ~subCode[SMSB-1:0]};
  end
endmodule

// File: rtl/dwd_datapath.sv
module dwd_datapath
  import dwd_pkg::*;
#(
  parameter int NCH        = DWD_NCH,
  parameter int WORD_W     = DWD_WORD_W,
  parameter int SUB_W      = DWD_SUB_W,
  parameter int CODING_BIT = DWD_CODING_BIT,
  parameter int BIAS_BIT   = DWD_BIAS_BIT,
  parameter int ROUTE_BIT  = DWD_ROUTE_BIT
) (
  input  logic                          clk,
  input  logic                          rst,
  input  dwdStrobe_t                    strb,
  input  logic [WORD_W-1:0]             wrData,
  output logic [NCH-1:0][WORD_W-1:0]    mainLvl,
  output logic [NCH-1:0][SUB_W-1:0]     subLvl,
  output logic [NCH-1:0]                subRoute,
  output logic [NCH-1:0]                biasInt,
  output logic                          codingTwos
);
  logic [NCH-1:0][WORD_W-1:0] mainCode;
  logic [NCH-1:0][SUB_W-1:0]  subCode;

  always_ff @(posedge clk) begin
    if (rst) begin
      mainCode   <= '0;
      subCode    <= '0;
      subRoute   <= '0;
      biasInt    <= '0;
      codingTwos <= 1'b0;
    end else begin
      if (strb.sysWr) codingTwos <= wrData[CODING_BIT];
      if (strb.ctlWr) begin
        subRoute[strb.chan] <= wrData[ROUTE_BIT];
        biasInt[strb.chan]  <= wrData[BIAS_BIT];
      end
      if (strb.datWr) begin
        if (subRoute[strb.chan]) subCode[strb.chan]  <= wrData[SUB_W-1:0];
        else                     mainCode[strb.chan] <= wrData;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_conv
    dwd_level_conv #(.MAIN_W(WORD_W), .SUB_W(SUB_W)) conv_i (
      .twos    (codingTwos),
      .mainCode(mainCode[ch]),
      .subCode (subCode[ch]),
      .mainLvl (mainLvl[ch]),
      .subLvl  (subLvl[ch])
    );
  end

  AST_SYS_CODING: assert property (@(posedge clk) disable iff (rst)
    strb.sysWr |=> codingTwos == $past(wrData[CODING_BIT])); // R2
  AST_CTL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    strb.ctlWr |=> (subRoute[$past(strb.chan)] == $past(wrData[ROUTE_BIT]))
                && (biasInt[$past(strb.chan)] == $past(wrData[BIAS_BIT]))); // R3
  AST_MAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strb.datWr && !subRoute[strb.chan]) |=>
      (mainCode[$past(strb.chan)] == $past(wrData)) && $stable(subCode)); // R4
  AST_SUB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (strb.datWr && subRoute[strb.chan]) |=>
      (subCode[$past(strb.chan)] == $past(wrData[SUB_W-1:0])) && $stable(mainCode)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strb.sysWr || strb.ctlWr || strb.datWr) |=>
      $stable(mainCode) && $stable(subCode) && $stable(subRoute)
      && $stable(biasInt) && $stable(codingTwos)); // R9
endmodule

// File: rtl/dac_write_decoder.sv
module dac_write_decoder
  import dwd_pkg::*;
#(
  parameter int NCH    = DWD_NCH,
  parameter int WORD_W = DWD_WORD_W,
  parameter int SUB_W  = DWD_SUB_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic                  modeSel,
  input  logic [DWD_ADDR_W-1:0] chanAddr,
  input  logic [WORD_W-1:0]     wrData,
  output logic [NCH*WORD_W-1:0] mainLevel,
  output logic [NCH*SUB_W-1:0]  subLevel,
  output logic [NCH-1:0]        subRoute,
  output logic [NCH-1:0]        biasInt,
  output logic                  codingTwos
);
  dwdStrobe_t                 strb;
  logic [NCH-1:0][WORD_W-1:0] mainLvl;
  logic [NCH-1:0][SUB_W-1:0]  subLvl;

  dwd_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .wrEn    (wrEn),
    .modeSel (modeSel),
    .chanAddr(chanAddr),
    .wrData  (wrData),
    .strb    (strb)
  );

  dwd_datapath #(.NCH(NCH), .WORD_W(WORD_W), .SUB_W(SUB_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .wrData    (wrData),
    .mainLvl   (mainLvl),
    .subLvl    (subLvl),
    .subRoute  (subRoute),
    .biasInt   (biasInt),
    .codingTwos(codingTwos)
  );

  assign mainLevel = mainLvl;
  assign subLevel  = subLvl;
endmodule

// File: tb/dac_write_decoder_tb_top.sv
module dac_write_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic modeSel = 1'b0;
  logic [2:0] chanAddr = '0;
  logic [9:0] wrData = '0;
  logic [79:0] mainLevel;
  logic [63:0] subLevel;
  logic [7:0] subRoute, biasInt;
  logic codingTwos;

  always #5 clk = ~clk;

  dac_write_decoder dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .modeSel(modeSel), .chanAddr(chanAddr),
    .wrData(wrData), .mainLevel(mainLevel), .subLevel(subLevel),
    .subRoute(subRoute), .biasInt(biasInt), .codingTwos(codingTwos)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // reference model state
  int mMain [8];
  int mSub  [8];
  bit [7:0] mRoute = '0;
  bit [7:0] mBias  = '0;
  bit mTwos = 1'b0;

  function automatic int expMain(int code, bit twos);
    int shifted = (code + 512) % 1024;
    return twos ? shifted : 1023 - shifted;
  endfunction

  function automatic int expSub(int code);
    return 255 - ((code + 128) % 256);
  endfunction

  task automatic cmp(string tag, int ch, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s ch%0d actual 0x%0h expected 0x%0h", tag, ch, act, exp);
    end
  endtask

  task automatic checkAll(string ctx, int addr, bit perChan);
    for (int ch = 0; ch < 8; ch++) begin
      string t = (perChan && ch != addr) ? "R10" : ctx;
      cmp({t, mTwos ? " R6" : " R7"}, ch, int'(mainLevel[ch*10 +: 10]),
          expMain(mMain[ch], mTwos));
      cmp({t, " R8"}, ch, int'(subLevel[ch*8 +: 8]), expSub(mSub[ch]));
    end
    cmp({ctx, " R3 route"}, -1, int'(subRoute), int'(mRoute));
    cmp({ctx, " R3 bias"}, -1, int'(biasInt), int'(mBias));
    cmp({ctx, " R2 coding"}, -1, int'(codingTwos), int'(mTwos));
  endtask

  // one write cycle; outputs sampled on the following falling edge
  task automatic doWrite(bit mode, int addr, int data);
    string ctx;
    bit perChan;
    @(negedge clk);
    wrEn = 1'b1; modeSel = mode; chanAddr = 3'(addr); wrData = 10'(data);
    @(negedge clk);
    wrEn = 1'b0;
    perChan = 1'b1;
    if (mode) begin
      if (mRoute[addr]) begin mSub[addr] = data % 256; ctx = "R5"; end
      else              begin mMain[addr] = data % 1024; ctx = "R4"; end
    end else if (data % 2 == 1) begin
      mRoute[addr] = data[7];
      mBias[addr]  = data[4];
      ctx = "R3";
    end else begin
      mTwos = data[5];
      ctx = "R2";
      perChan = 1'b0;
    end
    checkAll(ctx, addr, perChan);
  endtask

  task automatic doIdle();
    @(negedge clk);
    wrEn = 1'b0; modeSel = 1'($urandom); chanAddr = 3'($urandom); wrData = 10'($urandom);
    @(negedge clk);
    checkAll("R9", 0, 1'b0);
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd4711);
    for (int ch = 0; ch < 8; ch++) begin mMain[ch] = 0; mSub[ch] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkAll("R1", 0, 1'b0);

    // system write with a non-zero address selects twos complement
    doWrite(1'b0, 7, 10'h020);
    doWrite(1'b1, 3, 10'h200);   // level 0
    doWrite(1'b1, 4, 10'h1FF);   // level full
    // switch to offset binary, address ignored
    doWrite(1'b0, 5, 10'h000);
    doWrite(1'b1, 3, 10'h1FF);
    doWrite(1'b1, 4, 10'h200);
    // route channel 5 to sub latch with internal bias
    doWrite(1'b0, 5, 10'h091);
    doWrite(1'b1, 5, 10'h080);
    doWrite(1'b1, 5, 10'h37F);
    doWrite(1'b0, 0, 10'h020);   // sub level must not follow coding
    // route back to main
    doWrite(1'b0, 5, 10'h011);
    doWrite(1'b1, 5, 10'h2AA);
    doIdle();
    doIdle();

    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(99);
      int a = $urandom_range(7);
      int d = $urandom_range(1023);
      if (r < 55)      doWrite(1'b1, a, d);
      else if (r < 80) doWrite(1'b0, a, d | 1);
      else if (r < 90) doWrite(1'b0, a, d & 10'h3FE);
      else             doIdle();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule